// File: doc/BRIEF.md
# Interrupt Aggregator with Read-Clear Status

This block gathers interrupt events from several on-chip sources and from one external active-low interrupt line, and turns them into a single active-low interrupt output. That output may be shared with other devices. The output is an open-drain driver. It is modelled as a pull enable: when the enable is high the line is pulled low, and when it is low the line is released. Internal sources deliver one-cycle pulses. The external line is first brought into the clock domain by a synchroniser. Only its high-to-low transition is recorded as an event.

A host reaches the block through a simple register port. Reads are combinational in the cycle `host_rd` is high, and writes take effect at the clock edge. The host programs an enable register to choose which pending conditions may raise the output. It reads a status register to learn which conditions fired, and that read clears every latched condition. A third register shows the present synchronised level of the external line, so the host can see whether the remote source still holds it low after the clear.

Top module: `irq_agg`

## Requirements
- R1: After reset the enable register and the latched status are zero, `irq_pull` is 0, and the synchroniser holds the released (high) level.
- R2: The enable register at address 0xC6 can be written and read back with all 8 bits. A write takes effect at the clock edge. Bit 0 is the global enable and bit i (i from 1 to 7) enables source i.
- R3: A pulse on `evt_pulse[i]`, for i in {1,2,3,4,6,7}, sets status bit i at the next edge whether or not it is enabled. Pulses on `evt_pulse[0]` and `evt_pulse[5]` have no effect.
- R4: A falling edge on `ext_irq_n` sets status bit 5. The bit is set at the third rising edge after the low level is first sampled, which allows for the two synchroniser flops and one edge-detect flop. A line that stays low does not set the bit again after a clear.
- R5: Status bit 0 as read reads 1 exactly when enable bit 0 is set and, for some i in 1..7, both enable bit i and latched status bit i are set.
- R6: `irq_pull` equals the status summary bit of R5 in every cycle.
- R7: A read at address 0xC7 returns the latched bits 7..1 with the summary in bit 0. The same access clears all latched bits at the edge, so `irq_pull` is released in the next cycle unless a new event arrives.
- R8: An event that arrives in the same cycle as a clearing status read is kept: its bit is set after that edge.
- R9: Writes to address 0xC7 or 0xC8 leave the status and enable registers unchanged.
- R10: A read at address 0xC8 returns the synchronised external level in bit 0, which is the pin value two edges earlier, with zeros in bits 7..1.
- R11: A read at any other address returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_addr | input | 8 | Register address |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 8 | Write data |
| host_rd | input | 1 | Read strobe; a status read clears the latched bits |
| host_rdata | output | 8 | Read data, valid while host_rd is high |
| evt_pulse | input | 8 | One-cycle event pulses from internal sources (bits 1-4, 6-7 used) |
| ext_irq_n | input | 1 | External active-low interrupt line, asynchronous |
| irq_pull | output | 1 | 1 pulls the shared active-low interrupt line low |

## Verification
The properties assume a few things about the inputs. The host strobes are known (never X) outside reset. Address and data are stable in any cycle that carries a strobe. Internal sources deliver clean single-cycle pulses. The stimulus drives every input on the falling clock edge, which keeps it synchronous and free of X values. It toggles the external line only occasionally, so both long low levels and isolated edges occur. It also places clearing reads in the same cycles as new pulses on purpose, so that the coincidence rule is exercised.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int REG_W   = 8;
    localparam int ADDR_W  = 8;
    localparam int SUM_BIT = 0;
    localparam int EXT_BIT = 5;

    localparam logic [ADDR_W-1:0] ADDR_ENABLE = 8'hC6;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'hC7;
    localparam logic [ADDR_W-1:0] ADDR_LEVEL  = 8'hC8;

    // bits that internal pulse sources may set: all but summary and external
    localparam logic [REG_W-1:0] INT_SRC_MASK =
        ~((REG_W'(1) << SUM_BIT) | (REG_W'(1) << EXT_BIT));

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_ENABLE,
        SEL_STATUS,
        SEL_LEVEL
    } reg_sel_e;

    typedef struct packed {
        logic            rd;
        logic            wr;
        reg_sel_e        sel;
        logic [REG_W-1:0] wdata;
    } host_req_t;

    function automatic reg_sel_e decode_addr(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        case (a)
            ADDR_ENABLE: s = SEL_ENABLE;
            ADDR_STATUS: s = SEL_STATUS;
            ADDR_LEVEL:  s = SEL_LEVEL;
            default:     s = SEL_NONE;
        endcase
        return s;
    endfunction

    function automatic logic any_enabled(input logic [REG_W-1:0] en,
                                         input logic [REG_W-1:0] st);
        logic hit;
        hit = 1'b0;
        for (int i = 0; i < REG_W; i++) begin
            if (i != SUM_BIT) hit = hit | (en[i] & st[i]);
        end
        return en[SUM_BIT] & hit;
    endfunction

endpackage

// File: rtl/irq_agg_sync.sv
module irq_agg_sync
    import irq_agg_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_n,
    output logic level,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain_q <= 1'b1;
                else     chain_q <= async_n;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain_q <= '1;
                else     chain_q <= {chain_q[STAGES-2:0], async_n};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= chain_q[LAST];
    end

    assign level = chain_q[LAST];
    assign fall  = prev_q & ~chain_q[LAST];

endmodule

// File: rtl/irq_agg_status.sv
module irq_agg_status
    import irq_agg_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [REG_W-1:0] evt_pulse,
    input  logic             ext_fall,
    input  logic             clear,
    output logic [REG_W-1:0] status_q
);
    logic [REG_W-1:0] set_vec;
    logic [REG_W-1:0] status_d;

    always_comb begin
        set_vec          = evt_pulse & INT_SRC_MASK;
        set_vec[EXT_BIT] = ext_fall;
        set_vec[SUM_BIT] = 1'b0;
    end

    // new events are ORed in after the clear so they survive it
    always_comb begin
        status_d = clear ? '0 : status_q;
        status_d = status_d | set_vec;
    end

    always_ff @(posedge clk) begin
        if (rst) status_q <= '0;
        else     status_q <= status_d;
    end

endmodule

// File: rtl/irq_agg_host.sv
module irq_agg_host
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              host_rd,
    input  logic [REG_W-1:0]  status_q,
    input  logic              summary,
    input  logic              ext_level,
    output logic [REG_W-1:0]  en_q,
    output logic              status_clear,
    output logic [REG_W-1:0]  host_rdata
);
    host_req_t req;

    always_comb begin
        req.rd    = host_rd;
        req.wr    = host_wr;
        req.sel   = decode_addr(host_addr);
        req.wdata = host_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)                                  en_q <= '0;
        else if (req.wr && req.sel == SEL_ENABLE) en_q <= req.wdata;
    end

    assign status_clear = req.rd && (req.sel == SEL_STATUS);

    always_comb begin
        host_rdata = '0;
        if (req.rd) begin
            case (req.sel)
                SEL_ENABLE: host_rdata = en_q;
                SEL_STATUS: begin
                    host_rdata          = status_q;
                    host_rdata[SUM_BIT] = summary;
                end
                SEL_LEVEL:  host_rdata[0] = ext_level;
                default:    host_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_agg.sv
module irq_agg
    import irq_agg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic              host_wr,
    input  logic [REG_W-1:0]  host_wdata,
    input  logic              host_rd,
    output logic [REG_W-1:0]  host_rdata,
    input  logic [REG_W-1:0]  evt_pulse,
    input  logic              ext_irq_n,
    output logic              irq_pull
);
    logic             ext_level;
    logic             ext_fall;
    logic             status_clear;
    logic             summary;
    logic [REG_W-1:0] en_q;
    logic [REG_W-1:0] status_q;

    irq_agg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_n (ext_irq_n),
        .level   (ext_level),
        .fall    (ext_fall)
    );

    irq_agg_status u_status (
        .clk       (clk),
        .rst       (rst),
        .evt_pulse (evt_pulse),
        .ext_fall  (ext_fall),
        .clear     (status_clear),
        .status_q  (status_q)
    );

    irq_agg_host u_host (
        .clk          (clk),
        .rst          (rst),
        .host_addr    (host_addr),
        .host_wr      (host_wr),
        .host_wdata   (host_wdata),
        .host_rd      (host_rd),
        .status_q     (status_q),
        .summary      (summary),
        .ext_level    (ext_level),
        .en_q         (en_q),
        .status_clear (status_clear),
        .host_rdata   (host_rdata)
    );

    assign summary  = any_enabled(en_q, status_q);
    assign irq_pull = summary;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk
    import irq_agg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] host_addr,
    input logic              host_wr,
    input logic [REG_W-1:0]  host_wdata,
    input logic              host_rd,
    input logic [REG_W-1:0]  evt_pulse,
    input logic              irq_pull,
    input logic [REG_W-1:0]  en_q,
    input logic [REG_W-1:0]  status_q,
    input logic              ext_fall
);
    logic [REG_W-1:0] int_evt;
    logic             status_rd;
    logic             quiet;

    assign int_evt   = evt_pulse & INT_SRC_MASK;
    assign status_rd = host_rd && (host_addr == ADDR_STATUS);
    assign quiet     = (int_evt == '0) && !ext_fall;

    // R1
    reset_release_chk: assert property (@(posedge clk) rst |=> !irq_pull && status_q == '0 && en_q == '0);

    // R2
    enable_write_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == ADDR_ENABLE) |=> en_q == $past(host_wdata));

    // R3
    pulse_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (int_evt != '0) |=> ((status_q & $past(int_evt)) == $past(int_evt)));

    // R4
    ext_edge_chk: assert property (@(posedge clk) disable iff (rst)
        ext_fall |=> status_q[EXT_BIT]);

    // R6
    pull_needs_global_chk: assert property (@(posedge clk) disable iff (rst)
        irq_pull |-> en_q[SUM_BIT]);

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && quiet) |=> (status_q == '0 && !irq_pull));

    // R8
    coincident_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (status_rd && int_evt != '0) |=> ((status_q & $past(int_evt)) != '0));

    // R9
    status_write_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr != ADDR_ENABLE && !status_rd && quiet)
            |=> $stable(status_q) && $stable(en_q));

    // R3
    summary_bit_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !status_q[SUM_BIT]);

endmodule

bind irq_agg irq_agg_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_wdata (host_wdata),
    .host_rd    (host_rd),
    .evt_pulse  (evt_pulse),
    .irq_pull   (irq_pull),
    .en_q       (en_q),
    .status_q   (status_q),
    .ext_fall   (ext_fall)
);

// File: tb/test_irq_agg.sv
module test_irq_agg;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] host_addr = 8'h00;
    logic       host_wr = 1'b0;
    logic [7:0] host_wdata = 8'h00;
    logic       host_rd = 1'b0;
    logic [7:0] host_rdata;
    logic [7:0] evt_pulse = 8'h00;
    logic       ext_irq_n = 1'b1;
    logic       irq_pull;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    // bench model of the requirements
    logic [7:0] m_en, m_st;
    logic       m_s1, m_s2, m_prev;

    always #2 clk = ~clk;   // 250 MHz

    irq_agg i_irq_agg (
        .clk        (clk),
        .rst        (rst),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_rd    (host_rd),
        .host_rdata (host_rdata),
        .evt_pulse  (evt_pulse),
        .ext_irq_n  (ext_irq_n),
        .irq_pull   (irq_pull)
    );

    function automatic logic exp_summary();
        return m_en[0] & |(m_en[7:1] & m_st[7:1]);
    endfunction

    function automatic logic [7:0] exp_read(input logic [7:0] a);
        case (a)
            8'hC6:   return m_en;
            8'hC7:   return {m_st[7:1], exp_summary()};
            8'hC8:   return {7'b0, m_s2};
            default: return 8'h00;
        endcase
    endfunction

    function automatic string read_tag(input logic [7:0] a);
        case (a)
            8'hC6:   return "R2";
            8'hC7:   return "R7/R5";
            8'hC8:   return "R10";
            default: return "R11";
        endcase
    endfunction

    task automatic model_reset();
        m_en = 8'h00; m_st = 8'h00;
        m_s1 = 1'b1; m_s2 = 1'b1; m_prev = 1'b1;
    endtask

    task automatic model_edge();
        logic [7:0] nw;
        nw    = evt_pulse & 8'hDE;
        nw[5] = m_prev & ~m_s2;
        if (host_rd && host_addr == 8'hC7) m_st = 8'h00;
        m_st = m_st | nw;
        if (host_wr && host_addr == 8'hC6) m_en = host_wdata;
        m_prev = m_s2; m_s2 = m_s1; m_s1 = ext_irq_n;
    endtask

    task automatic step(input logic rd, input logic wr, input logic [7:0] addr,
                        input logic [7:0] wd, input logic [7:0] ev, input logic ext,
                        input string tag);
        logic [7:0] er;
        @(negedge clk);
        host_rd = rd; host_wr = wr; host_addr = addr;
        host_wdata = wd; evt_pulse = ev; ext_irq_n = ext;
        #1;
        checks++;
        if (irq_pull !== exp_summary()) begin
            errors++;
            $display("FAIL R6 %s: irq_pull=%0b expected %0b", tag, irq_pull, exp_summary());
        end
        if (rd) begin
            er = exp_read(addr);
            checks++;
            if (host_rdata !== er) begin
                errors++;
                $display("FAIL %s %s: addr %h rdata=%h expected %h",
                         read_tag(addr), tag, addr, host_rdata, er);
            end
        end
        @(posedge clk);
        model_edge();
    endtask

    task automatic idle(input int n, input logic ext, input string tag);
        for (int i = 0; i < n; i++) step(0, 0, 8'h00, 8'h00, 8'h00, ext, tag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic ext_r;
        model_reset();
        void'($urandom(32'd20231));
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state
        step(1, 0, 8'hC6, 8'h00, 8'h00, 1'b1, "R1 enable after reset");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b1, "R1 status after reset");
        step(1, 0, 8'hC8, 8'h00, 8'h00, 1'b1, "R1 level after reset");

        // R2: enable write and readback
        step(0, 1, 8'hC6, 8'hA5, 8'h00, 1'b1, "R2 write");
        step(1, 0, 8'hC6, 8'h00, 8'h00, 1'b1, "R2 readback");

        // R3: disabled sources still latch; bits 0 and 5 of pulses ignored
        step(0, 1, 8'hC6, 8'h00, 8'h00, 1'b1, "R3 disable all");
        step(0, 0, 8'h00, 8'h00, 8'h21, 1'b1, "R3 ignored pulse bits");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b1, "R3 no latch for bits 0,5");
        step(0, 0, 8'h00, 8'h00, 8'h12, 1'b1, "R3 pulse disabled");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b1, "R3 status read");

        // R4/R6: external falling edge raises the output, held low no retrigger
        step(0, 1, 8'hC6, 8'h21, 8'h00, 1'b1, "R4 enable ext");
        idle(5, 1'b0, "R4 edge latency");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b0, "R4 read ext");
        idle(10, 1'b0, "R4 held low no retrigger");
        step(1, 0, 8'hC8, 8'h00, 8'h00, 1'b0, "R10 live low");
        idle(4, 1'b1, "R4 release");
        idle(5, 1'b0, "R4 second edge");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b0, "R4 second read");

        // R8: event coinciding with clearing read
        step(0, 1, 8'hC6, 8'hFF, 8'h00, 1'b1, "R8 enable all");
        step(0, 0, 8'h00, 8'h00, 8'h08, 1'b1, "R8 first event");
        step(1, 0, 8'hC7, 8'h00, 8'h04, 1'b1, "R8 read with event");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b1, "R8 kept bit");

        // R9: writes to status and level ignored
        step(0, 0, 8'h00, 8'h00, 8'h40, 1'b1, "R9 set bit6");
        step(0, 1, 8'hC7, 8'h00, 8'h00, 1'b1, "R9 write status");
        step(0, 1, 8'hC8, 8'hFF, 8'h00, 1'b1, "R9 write level");
        step(1, 0, 8'hC6, 8'h00, 8'h00, 1'b1, "R9 enable intact");
        step(1, 0, 8'hC7, 8'h00, 8'h00, 1'b1, "R9 status intact");

        // R11: unmapped
        step(1, 0, 8'h10, 8'h00, 8'h00, 1'b1, "R11 unmapped");

        // random mix
        ext_r = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            logic       rd, wr;
            logic [7:0] a, wd, ev;
            if ($urandom % 10 == 0) ext_r = ~ext_r;
            rd = ($urandom % 4 == 0);
            wr = ($urandom % 10 == 0);
            case ($urandom % 5)
                0:       a = 8'hC6;
                1, 2:    a = 8'hC7;
                3:       a = 8'hC8;
                default: a = 8'($urandom);
            endcase
            wd = 8'($urandom);
            if ($urandom % 4 != 0) wd[0] = 1'b1;
            ev = ($urandom % 6 == 0) ? 8'($urandom) : 8'h00;
            step(rd, wr, a, wd, ev, ext_r, "random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule